// File: doc/BRIEF.md
# GPIO Edge Detect Interrupt Unit

This block watches up to four banks of 32 general-purpose pins and turns level changes on input pins into sticky per-pin status bits. Each bank has its own rising-edge enable, falling-edge enable and edge-status register. Software reaches them over a simple register bus with a write strobe and a combinational read port. Pin direction is not stored here. It arrives as an input from the neighbouring GPIO register block, and a pin marked as an output never records an edge.

The status bits feed three level-sensitive, active-high interrupt lines:

- Two dedicated lines, one for each of the two lowest pins of bank 0.
- One shared line, which is the OR of every other status bit.

A fixed per-bank mask marks the pins that can wake a halted processor. When any such input pin changes level while the halted input is high, the unit raises a one-cycle wake request.

Top module: `gpio_edge_irq`

## Requirements
- R1: Register map (9-bit byte address, 32-bit data).
  - Rising-enable registers for banks 0, 1, 2, 3 sit at 0x030, 0x034, 0x038, 0x130.
  - Falling-enable registers sit at 0x03C, 0x040, 0x044, 0x13C.
  - Status registers sit at 0x048, 0x04C, 0x050, 0x148.
  - Enable registers read back what was written.
  - Any other address reads 0, and a write to it changes no register.
- R2: Pin 32*b+n corresponds to bit n of bank b. A pin_is_out bit of 0 means input. If an input pin is sampled low at one clock edge and high at the next, and its rising enable is set, its status bit becomes 1 at that second edge.
- R3: An input pin with its falling enable set that is sampled high and then low sets its status bit in the same way.
- R4: A pin whose pin_is_out bit is 1 never sets its status bit. A pin whose matching enable is clear does not set it either.
- R5: Writing a 1 to a status bit clears it. Writing 0 leaves it unchanged. A set bit stays set until it is cleared.
- R6: If an edge sets a status bit at the same clock edge as a write that clears it, the bit ends up set.
- R7: irq_pin0 equals status bit 0 of bank 0, and irq_pin1 equals status bit 1 of bank 0. Both are registered and updated at the same clock edge as the status bit.
- R8: irq_shared is the registered OR of bank 0 bits 2..31 and all bits of the other banks.
- R9: Wake request.
  - The wake masks for banks 0..3 are 0x8003FE1B, 0x002001FC, 0xEC080000 and 0x0012007F.
  - wake_req is high for the cycle after a clock edge at which cpu_halted was high and a masked input pin differed from its level at the previous edge.
  - Pins outside the mask, output pins, and any change while cpu_halted is low leave wake_req low.
- R10: Synchronous reset.
  - rst clears all enables, all status bits and the stored previous pin levels.
  - It drives every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_level | input | 128 | Synchronized pin levels, pin 32*b+n at bit 32*b+n |
| pin_is_out | input | 128 | Direction per pin, 1 = output |
| cpu_halted | input | 1 | Processor halted indication |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 9 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq_pin0 | output | 1 | Interrupt for bank 0 pin 0 |
| irq_pin1 | output | 1 | Interrupt for bank 0 pin 1 |
| irq_shared | output | 1 | Interrupt for all remaining pins |
| wake_req | output | 1 | One-cycle wake request |

## Verification
The embedded assertions check four properties on every cycle:

- Output-configured pins never set a status bit.
- A status bit only falls after a write of 1 to it.
- The two dedicated interrupt lines track their status bits.
- The shared line matches the OR of the remaining status bits, and the wake pulse only follows a halted cycle.

The directed scenarios cover what needs chosen stimulus: the exact register addresses, the rising and falling detection, set-over-clear priority when an edge and a clear land together, and which pins the wake masks admit or reject.

// File: rtl/gpio_edge_pkg.sv
package gpio_edge_pkg;

    localparam int BANK_W = 32;
    localparam int ADDR_W = 9;

    typedef enum logic [1:0] {
        KIND_RISE = 2'd0,
        KIND_FALL = 2'd1,
        KIND_STAT = 2'd2
    } reg_kind_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic clr;
    } bank_wr_t;

    function automatic logic [ADDR_W-1:0] kind_base(reg_kind_e k);
        case (k)
            KIND_RISE: return ADDR_W'(12'h030);
            KIND_FALL: return ADDR_W'(12'h03C);
            default:   return ADDR_W'(12'h048);
        endcase
    endfunction

    // Banks 0..2 are packed at a 4-byte stride; bank 3 and above sit in the upper page.
    function automatic logic [ADDR_W-1:0] reg_addr(reg_kind_e k, int unsigned b);
        int unsigned off;
        off = (b < 3) ? 4 * b : 'h100 + 4 * (b - 3);
        return kind_base(k) + ADDR_W'(off);
    endfunction

    function automatic logic [BANK_W-1:0] wake_mask(int unsigned b);
        case (b)
            0:       return 32'h8003FE1B;
            1:       return 32'h002001FC;
            2:       return 32'hEC080000;
            3:       return 32'h0012007F;
            default: return '0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_edge_bank.sv
module gpio_edge_bank
    import gpio_edge_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [BANK_W-1:0] lvl,
    input  logic [BANK_W-1:0] is_out,
    input  bank_wr_t          wr,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] rise_en,
    output logic [BANK_W-1:0] fall_en,
    output logic [BANK_W-1:0] status,
    output logic [BANK_W-1:0] status_nxt,
    output logic [BANK_W-1:0] change
);

    logic [BANK_W-1:0] prev_lvl;
    logic [BANK_W-1:0] hit;
    logic [BANK_W-1:0] clr_mask;

    always_comb begin
        hit        = ~is_out & ((lvl & ~prev_lvl & rise_en) | (~lvl & prev_lvl & fall_en));
        clr_mask   = wr.clr ? wdata : '0;
        status_nxt = (status & ~clr_mask) | hit;
        change     = (lvl ^ prev_lvl) & ~is_out;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_lvl <= '0;
            rise_en  <= '0;
            fall_en  <= '0;
            status   <= '0;
        end else begin
            prev_lvl <= lvl;
            if (wr.rise) rise_en <= wdata;
            if (wr.fall) fall_en <= wdata;
            status <= status_nxt;
        end
    end

    // R4: a newly set status bit never belongs to an output pin
    assert_out_no_set_R4: assert property (@(posedge clk) disable iff (rst)
        ((status & ~$past(status) & $past(is_out)) == '0));

    // R5: a status bit only drops where a clearing write had a 1
    assert_sticky_R5: assert property (@(posedge clk) disable iff (rst)
        (($past(status) & ~status & ~$past(clr_mask)) == '0));

endmodule

// File: rtl/gpio_irq_merge.sv
module gpio_irq_merge
    import gpio_edge_pkg::*;
#(
    parameter int NUM_BANKS = 4
) (
    input  logic                             clk,
    input  logic                             rst,
    input  logic [NUM_BANKS-1:0][BANK_W-1:0] status_nxt,
    input  logic [NUM_BANKS-1:0][BANK_W-1:0] change,
    input  logic                             halted,
    output logic                             irq0,
    output logic                             irq1,
    output logic                             irq_rest,
    output logic                             wake
);

    logic [NUM_BANKS-1:0] bank_rest;
    logic [NUM_BANKS-1:0] bank_wake;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        if (b == 0) begin : g_first
            assign bank_rest[b] = |status_nxt[b][BANK_W-1:2];
        end else begin : g_other
            assign bank_rest[b] = |status_nxt[b];
        end
        assign bank_wake[b] = |(change[b] & wake_mask(b));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            irq0     <= 1'b0;
            irq1     <= 1'b0;
            irq_rest <= 1'b0;
            wake     <= 1'b0;
        end else begin
            irq0     <= status_nxt[0][0];
            irq1     <= status_nxt[0][1];
            irq_rest <= |bank_rest;
            wake     <= halted & (|bank_wake);
        end
    end

    // R9: a wake pulse is only raised after a halted cycle
    assert_wake_halted_R9: assert property (@(posedge clk) disable iff (rst)
        wake |-> $past(halted));

endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq
    import gpio_edge_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    localparam int PINS = NUM_BANKS * BANK_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [PINS-1:0]   pin_level,
    input  logic [PINS-1:0]   pin_is_out,
    input  logic              cpu_halted,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BANK_W-1:0] bus_wdata,
    output logic [BANK_W-1:0] bus_rdata,
    output logic              irq_pin0,
    output logic              irq_pin1,
    output logic              irq_shared,
    output logic              wake_req
);

    bank_wr_t                         wr_sel [NUM_BANKS];
    logic [NUM_BANKS-1:0][BANK_W-1:0] rise_q;
    logic [NUM_BANKS-1:0][BANK_W-1:0] fall_q;
    logic [NUM_BANKS-1:0][BANK_W-1:0] stat_q;
    logic [NUM_BANKS-1:0][BANK_W-1:0] stat_nxt;
    logic [NUM_BANKS-1:0][BANK_W-1:0] chg;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        always_comb begin
            wr_sel[b].rise = bus_wr && (bus_addr == reg_addr(KIND_RISE, b));
            wr_sel[b].fall = bus_wr && (bus_addr == reg_addr(KIND_FALL, b));
            wr_sel[b].clr  = bus_wr && (bus_addr == reg_addr(KIND_STAT, b));
        end

        gpio_edge_bank u_bank (
            .clk        (clk),
            .rst        (rst),
            .lvl        (pin_level[b*BANK_W +: BANK_W]),
            .is_out     (pin_is_out[b*BANK_W +: BANK_W]),
            .wr         (wr_sel[b]),
            .wdata      (bus_wdata),
            .rise_en    (rise_q[b]),
            .fall_en    (fall_q[b]),
            .status     (stat_q[b]),
            .status_nxt (stat_nxt[b]),
            .change     (chg[b])
        );
    end

    always_comb begin
        bus_rdata = '0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bus_addr == reg_addr(KIND_RISE, b)) bus_rdata = rise_q[b];
            if (bus_addr == reg_addr(KIND_FALL, b)) bus_rdata = fall_q[b];
            if (bus_addr == reg_addr(KIND_STAT, b)) bus_rdata = stat_q[b];
        end
    end

    gpio_irq_merge #(.NUM_BANKS(NUM_BANKS)) u_merge (
        .clk        (clk),
        .rst        (rst),
        .status_nxt (stat_nxt),
        .change     (chg),
        .halted     (cpu_halted),
        .irq0       (irq_pin0),
        .irq1       (irq_pin1),
        .irq_rest   (irq_shared),
        .wake       (wake_req)
    );

    logic [PINS-1:0] rest_bits;
    assign rest_bits = stat_q & ~PINS'(3);

    // R7: dedicated lines agree with the bank 0 status register
    assert_dedicated_lines_R7: assert property (@(posedge clk) disable iff (rst)
        (irq_pin0 == stat_q[0][0]) && (irq_pin1 == stat_q[0][1]));

    // R8: shared line agrees with the remaining status bits
    assert_shared_line_R8: assert property (@(posedge clk) disable iff (rst)
        irq_shared == (|rest_bits));

endmodule

// File: tb/gpio_edge_irq_test.sv
module gpio_edge_irq_test;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [127:0] pin_level = '0;
    logic [127:0] pin_is_out = '0;
    logic         cpu_halted = 1'b0;
    logic         bus_wr = 1'b0;
    logic [8:0]   bus_addr = '0;
    logic [31:0]  bus_wdata = '0;
    logic [31:0]  bus_rdata;
    logic         irq_pin0, irq_pin1, irq_shared, wake_req;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    gpio_edge_irq uut (
        .clk(clk), .rst(rst), .pin_level(pin_level), .pin_is_out(pin_is_out),
        .cpu_halted(cpu_halted), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_pin0(irq_pin0),
        .irq_pin1(irq_pin1), .irq_shared(irq_shared), .wake_req(wake_req)
    );

    always #10 clk = ~clk;

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [8:0] a, input logic [31:0] d);
        bus_addr = a;
        bus_wdata = d;
        bus_wr = 1'b1;
        step();
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [8:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic chk_reg(input string req, input logic [8:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        chk(req, v, exp);
    endtask

    task automatic t_reset();
        logic [8:0] addrs [12] = '{9'h030, 9'h034, 9'h038, 9'h130, 9'h03C, 9'h040,
                                   9'h044, 9'h13C, 9'h048, 9'h04C, 9'h050, 9'h148};
        chk("R10 irqs/wake", {28'd0, irq_pin0, irq_pin1, irq_shared, wake_req}, 32'd0);
        for (int i = 0; i < 12; i++) chk_reg("R10 reg zero", addrs[i], 32'd0);
    endtask

    task automatic t_regmap();
        wr(9'h030, 32'h11111111); wr(9'h034, 32'h22222222);
        wr(9'h038, 32'h33333333); wr(9'h130, 32'h44444444);
        wr(9'h03C, 32'h55555555); wr(9'h040, 32'h66666666);
        wr(9'h044, 32'h77777777); wr(9'h13C, 32'h88888888);
        chk_reg("R1 rise b0", 9'h030, 32'h11111111);
        chk_reg("R1 rise b1", 9'h034, 32'h22222222);
        chk_reg("R1 rise b2", 9'h038, 32'h33333333);
        chk_reg("R1 rise b3", 9'h130, 32'h44444444);
        chk_reg("R1 fall b0", 9'h03C, 32'h55555555);
        chk_reg("R1 fall b3", 9'h13C, 32'h88888888);
        wr(9'h054, 32'hFFFFFFFF);
        wr(9'h000, 32'hFFFFFFFF);
        chk_reg("R1 unmapped read", 9'h054, 32'd0);
        chk_reg("R1 unmapped write ignored", 9'h030, 32'h11111111);
        chk_reg("R1 unmapped write ignored", 9'h044, 32'h77777777);
        for (int b = 0; b < 4; b++) begin
            wr((b < 3) ? 9'(9'h030 + 4*b) : 9'h130, 32'd0);
            wr((b < 3) ? 9'(9'h03C + 4*b) : 9'h13C, 32'd0);
        end
    endtask

    task automatic t_rise();
        wr(9'h034, 32'h00000020);
        pin_level[37] = 1'b1;
        step();
        chk_reg("R2 rise sets b1 bit5", 9'h04C, 32'h00000020);
        chk("R8 shared high", {31'd0, irq_shared}, 32'd1);
        chk("R7 dedicated low", {30'd0, irq_pin0, irq_pin1}, 32'd0);
        pin_level[37] = 1'b0;
        step();
        chk_reg("R4 falling with no enable", 9'h04C, 32'h00000020);
    endtask

    task automatic t_clear();
        wr(9'h04C, 32'h00000000);
        chk_reg("R5 write 0 keeps", 9'h04C, 32'h00000020);
        wr(9'h04C, 32'hFFFFFFDF);
        chk_reg("R5 other ones keep", 9'h04C, 32'h00000020);
        wr(9'h04C, 32'h00000020);
        chk_reg("R5 write 1 clears", 9'h04C, 32'h00000000);
        chk("R8 shared low", {31'd0, irq_shared}, 32'd0);
    endtask

    task automatic t_fall();
        wr(9'h03C, 32'h00000001);
        pin_level[0] = 1'b1;
        step();
        chk_reg("R3 rise not enabled", 9'h048, 32'd0);
        pin_level[0] = 1'b0;
        step();
        chk_reg("R3 fall sets b0 bit0", 9'h048, 32'h00000001);
        chk("R7 irq_pin0", {31'd0, irq_pin0}, 32'd1);
        chk("R8 shared excludes pin0", {31'd0, irq_shared}, 32'd0);
        wr(9'h048, 32'h00000001);
        chk("R7 irq_pin0 cleared", {31'd0, irq_pin0}, 32'd0);
        wr(9'h03C, 32'd0);
    endtask

    task automatic t_output();
        wr(9'h030, 32'h00000002);
        pin_is_out[1] = 1'b1;
        pin_level[1] = 1'b1;
        step();
        chk_reg("R4 output pin no status", 9'h048, 32'd0);
        chk("R4 output pin no irq", {31'd0, irq_pin1}, 32'd0);
        pin_level[1] = 1'b0;
        step();
        pin_is_out[1] = 1'b0;
        pin_level[70] = 1'b1;
        step();
        chk_reg("R4 disabled pin no status", 9'h050, 32'd0);
        pin_level[70] = 1'b0;
        pin_level[1] = 1'b1;
        step();
        chk("R7 irq_pin1", {31'd0, irq_pin1}, 32'd1);
        chk("R8 shared excludes pin1", {31'd0, irq_shared}, 32'd0);
        pin_level[1] = 1'b0;
        wr(9'h048, 32'h00000002);
        chk("R7 irq_pin1 cleared", {31'd0, irq_pin1}, 32'd0);
        wr(9'h030, 32'd0);
    endtask

    task automatic t_collide();
        wr(9'h130, 32'h00000100);
        bus_addr = 9'h148;
        bus_wdata = 32'h00000100;
        bus_wr = 1'b1;
        pin_level[104] = 1'b1;
        step();
        bus_wr = 1'b0;
        chk_reg("R6 set wins over clear", 9'h148, 32'h00000100);
        chk("R8 shared from bank3", {31'd0, irq_shared}, 32'd1);
        wr(9'h148, 32'h00000100);
        chk_reg("R6 later clear", 9'h148, 32'd0);
        pin_level[104] = 1'b0;
        wr(9'h130, 32'd0);
    endtask

    task automatic t_wake();
        cpu_halted = 1'b1;
        step();
        pin_level[0] = 1'b1;
        step();
        chk("R9 masked pin0 wakes", {31'd0, wake_req}, 32'd1);
        step();
        chk("R9 one cycle pulse", {31'd0, wake_req}, 32'd0);
        pin_level[2] = 1'b1;
        step();
        chk("R9 unmasked pin2 no wake", {31'd0, wake_req}, 32'd0);
        pin_level[96] = 1'b1;
        step();
        chk("R9 bank3 pin0 wakes", {31'd0, wake_req}, 32'd1);
        pin_is_out[31] = 1'b1;
        pin_level[31] = 1'b1;
        step();
        chk("R9 output pin no wake", {31'd0, wake_req}, 32'd0);
        cpu_halted = 1'b0;
        pin_level[0] = 1'b0;
        step();
        chk("R9 not halted no wake", {31'd0, wake_req}, 32'd0);
        pin_level[83] = 1'b1;
        cpu_halted = 1'b1;
        step();
        chk("R9 bank2 bit19 wakes", {31'd0, wake_req}, 32'd1);
        cpu_halted = 1'b0;
        chk_reg("R4 no enables no status", 9'h048, 32'd0);
    endtask

    initial begin
        #(20 * 100000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) step();
        rst = 1'b0;
        step();
        t_reset();
        t_regmap();
        t_rise();
        t_clear();
        t_fall();
        t_output();
        t_collide();
        t_wake();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule